// File: doc/BRIEF.md
# Dual-Slot Load Execute Pipeline

This block is the load side of the execute stage in a wide-issue DSP datapath. Each of its load slots accepts one load per cycle. A load carries a size, a signedness flag, a base register value with its index, a post-increment offset and a destination index. The first execute phase is the issue cycle. In that phase the block puts the incremented base onto a base write port, so the next instruction already reads the new base. The memory read uses the unmodified base. The loaded value leaves on a result write port in the fifth execute phase, four cycles after issue. That gives four delay slots, and the count never depends on where the data came from.

Slower memory never adds delay slots. When any slot's memory request is not ready, every execute stage of every slot freezes together. `pipe_hold` tells the surrounding pipeline to freeze as well, and an issue offered during a hold is ignored. Sub-word loads pick their lane from the low address bits and are either sign-extended or zero-extended. A misaligned address produces an error pulse in place of a result.

Top module: `load_exec_unit`

## Requirements
- R1: With no hold, a load issued in cycle c asserts `rwr_valid` for its slot in cycle c+4 only, with `rwr_idx` equal to its destination index.
- R2: In the issue cycle the base write port carries `bwr_idx` = base index and `bwr_data` = base + offset. The memory request, which appears in cycle c+2, uses the unmodified base as `mem_addr`.
- R3: Size code 2'b10 (word) returns the full 32-bit word. Size code 2'b11 behaves exactly as a word load.
- R4: Size code 2'b01 (halfword) takes bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1. The value is sign-extended when `iss_unsigned` is 0 and zero-extended when it is 1.
- R5: Size code 2'b00 (byte) takes the byte at lane address[1:0], with lane 0 in bits 7:0 (little-endian). It is sign-extended or zero-extended as in R4.
- R6: While a slot holds `mem_req` high with `mem_ready` low, `pipe_hold` is high and every stage of both slots is frozen. Each pending result is delayed by exactly the number of hold cycles, and an issue offered during a hold causes no base write and no result.
- R7: Loads issued in consecutive cycles produce results in consecutive cycles and in issue order. There is no interlock, so two loads to the same destination both write.
- R8: Both slots accept a load in the same cycle. Their results come out in the same cycle, each with its own index and data.
- R9: A halfword at an odd address, or a word at an address whose low two bits are nonzero, issues no memory request and no result write. It pulses `misalign_err` in cycle c+4, and its base write still happens.
- R10: After reset, `rwr_valid`, `bwr_valid`, `mem_req`, `misalign_err` and `pipe_hold` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | NSLOT | Load offered in this cycle, one bit per slot |
| iss_size | input | NSLOT x 2 | Size code per slot: 00 byte, 01 halfword, 10/11 word |
| iss_unsigned | input | NSLOT | Zero-extend instead of sign-extend |
| iss_base | input | NSLOT x 32 | Base register value (the load address) |
| iss_offset | input | NSLOT x 32 | Post-increment added to the base |
| iss_breg | input | NSLOT x 5 | Base register index |
| iss_dst | input | NSLOT x 5 | Destination register index |
| pipe_hold | output | 1 | Global freeze, high while any memory request is not ready |
| bwr_valid | output | NSLOT | Base register write strobe |
| bwr_idx | output | NSLOT x 5 | Base register write index |
| bwr_data | output | NSLOT x 32 | Incremented base value |
| mem_req | output | NSLOT | Memory read request |
| mem_addr | output | NSLOT x 32 | Byte address of the request |
| mem_rdata | input | NSLOT x 32 | Word returned by memory |
| mem_ready | input | NSLOT | Memory data valid in this cycle |
| rwr_valid | output | NSLOT | Result register write strobe |
| rwr_idx | output | NSLOT x 5 | Result destination index |
| rwr_data | output | NSLOT x 32 | Sized and extended load result |
| misalign_err | output | NSLOT | Error pulse for a misaligned load |

## Verification
A stage register that fails to advance or fails to freeze shows up at the ports as a result strobe one or more cycles away from c+4 plus the hold count. The bench can see this within five cycles of issue. A wrong size, lane or signedness field in a stage appears in `rwr_data` in the result cycle itself, so each lane and extension mode gets its own load. A lost error bit shows up in the same cycle as an unexpected `mem_req` or `rwr_valid`. A leaked issue during a hold shows up at once as a spurious `bwr_valid`.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int LANES = XLEN / 8;
    localparam int LOW = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } ld_size_e;

    // control carried through phases two and three
    typedef struct packed {
        logic            valid;
        logic            err;
        ld_size_e        size;
        logic            uns;
        logic [RIDX-1:0] dst;
        logic [XLEN-1:0] addr;
    } ld_ctl_t;

    // result carried through phases four and five
    typedef struct packed {
        logic            valid;
        logic            err;
        logic [RIDX-1:0] dst;
        logic [XLEN-1:0] data;
    } ld_res_t;

    function automatic logic bad_align(ld_size_e sz, logic [LOW-1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            default: return |lo;
        endcase
    endfunction
endpackage

// File: rtl/ldu_agen.sv
module ldu_agen
    import ldu_pkg::*;
(
    input  logic            valid,
    input  logic            advance,
    input  ld_size_e        size,
    input  logic            uns,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic [RIDX-1:0] breg,
    input  logic [RIDX-1:0] dst,
    output logic            bwr_valid,
    output logic [RIDX-1:0] bwr_idx,
    output logic [XLEN-1:0] bwr_data,
    output ld_ctl_t         e1
);
    logic take;

    assign take      = valid & advance;
    // post-increment committed at the end of phase one
    assign bwr_valid = take;
    assign bwr_idx   = breg;
    assign bwr_data  = base + offset;

    always_comb begin
        e1.valid = take;
        e1.err   = bad_align(size, base[LOW-1:0]);
        e1.size  = size;
        e1.uns   = uns;
        e1.dst   = dst;
        e1.addr  = base;
    end
endmodule

// File: rtl/ldu_lane.sv
module ldu_lane
    import ldu_pkg::*;
(
    input  ld_size_e        size,
    input  logic            uns,
    input  logic [LOW-1:0]  lo,
    input  logic [XLEN-1:0] word,
    output logic [XLEN-1:0] data
);
    logic [7:0]  bsel;
    logic [15:0] hsel;
    logic        bsign;
    logic        hsign;

    always_comb begin
        case (lo)
            2'd0:    bsel = word[7:0];
            2'd1:    bsel = word[15:8];
            2'd2:    bsel = word[23:16];
            default: bsel = word[31:24];
        endcase
        hsel  = lo[1] ? word[31:16] : word[15:0];
        bsign = bsel[7] & ~uns;
        hsign = hsel[15] & ~uns;
        case (size)
            SZ_BYTE: data = {{(XLEN-8){bsign}}, bsel};
            SZ_HALF: data = {{(XLEN-16){hsign}}, hsel};
            default: data = word;
        endcase
    end
endmodule

// File: rtl/ldu_slot.sv
module ldu_slot
    import ldu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  ld_ctl_t         e1,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            hold_req,
    output logic            rwr_valid,
    output logic [RIDX-1:0] rwr_idx,
    output logic [XLEN-1:0] rwr_data,
    output logic            err_pulse
);
    ld_ctl_t e2_q, e3_q;
    ld_res_t e4_q, e5_q;
    ld_res_t e3_res;
    logic [XLEN-1:0] sized;

    ldu_lane u_lane (
        .size (e3_q.size),
        .uns  (e3_q.uns),
        .lo   (e3_q.addr[LOW-1:0]),
        .word (mem_rdata),
        .data (sized)
    );

    assign mem_req  = e3_q.valid & ~e3_q.err;
    assign mem_addr = e3_q.addr;
    assign hold_req = mem_req & ~mem_ready;

    always_comb begin
        e3_res.valid = e3_q.valid;
        e3_res.err   = e3_q.err;
        e3_res.dst   = e3_q.dst;
        e3_res.data  = e3_q.err ? '0 : sized;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e2_q <= '0;
            e3_q <= '0;
            e4_q <= '0;
            e5_q <= '0;
        end else if (advance) begin
            e2_q <= e1;
            e3_q <= e2_q;
            e4_q <= e3_res;
            e5_q <= e4_q;
        end
    end

    // write happens once, at the edge that closes phase five
    assign rwr_valid = e5_q.valid & ~e5_q.err & advance;
    assign rwr_idx   = e5_q.dst;
    assign rwr_data  = e5_q.data;
    assign err_pulse = e5_q.valid & e5_q.err & advance;

    a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(e2_q) && $stable(e3_q) && $stable(e4_q) && $stable(e5_q));

    a_r1_phase_advance: assert property (@(posedge clk) disable iff (rst)
        advance && e4_q.valid |=> e5_q.valid);

    a_r9_half_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req && e3_q.size == SZ_HALF |-> !e3_q.addr[0]);

    a_r9_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req && e3_q.size[1] |-> e3_q.addr[LOW-1:0] == '0);

    a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        advance && mem_req && e3_q.uns && e3_q.size == SZ_BYTE |=> e4_q.data[XLEN-1:8] == '0);
endmodule

// File: rtl/load_exec_unit.sv
module load_exec_unit
    import ldu_pkg::*;
#(
    parameter int NSLOT = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSLOT-1:0]            iss_valid,
    input  logic [NSLOT-1:0][1:0]       iss_size,
    input  logic [NSLOT-1:0]            iss_unsigned,
    input  logic [NSLOT-1:0][XLEN-1:0]  iss_base,
    input  logic [NSLOT-1:0][XLEN-1:0]  iss_offset,
    input  logic [NSLOT-1:0][RIDX-1:0]  iss_breg,
    input  logic [NSLOT-1:0][RIDX-1:0]  iss_dst,
    output logic                        pipe_hold,
    output logic [NSLOT-1:0]            bwr_valid,
    output logic [NSLOT-1:0][RIDX-1:0]  bwr_idx,
    output logic [NSLOT-1:0][XLEN-1:0]  bwr_data,
    output logic [NSLOT-1:0]            mem_req,
    output logic [NSLOT-1:0][XLEN-1:0]  mem_addr,
    input  logic [NSLOT-1:0][XLEN-1:0]  mem_rdata,
    input  logic [NSLOT-1:0]            mem_ready,
    output logic [NSLOT-1:0]            rwr_valid,
    output logic [NSLOT-1:0][RIDX-1:0]  rwr_idx,
    output logic [NSLOT-1:0][XLEN-1:0]  rwr_data,
    output logic [NSLOT-1:0]            misalign_err
);
    logic [NSLOT-1:0] hold_req;
    logic             advance;

    assign pipe_hold = |hold_req;
    assign advance   = ~pipe_hold;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ld_ctl_t e1;

        ldu_agen u_agen (
            .valid     (iss_valid[g]),
            .advance   (advance),
            .size      (ld_size_e'(iss_size[g])),
            .uns       (iss_unsigned[g]),
            .base      (iss_base[g]),
            .offset    (iss_offset[g]),
            .breg      (iss_breg[g]),
            .dst       (iss_dst[g]),
            .bwr_valid (bwr_valid[g]),
            .bwr_idx   (bwr_idx[g]),
            .bwr_data  (bwr_data[g]),
            .e1        (e1)
        );

        ldu_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .advance   (advance),
            .e1        (e1),
            .mem_req   (mem_req[g]),
            .mem_addr  (mem_addr[g]),
            .mem_rdata (mem_rdata[g]),
            .mem_ready (mem_ready[g]),
            .hold_req  (hold_req[g]),
            .rwr_valid (rwr_valid[g]),
            .rwr_idx   (rwr_idx[g]),
            .rwr_data  (rwr_data[g]),
            .err_pulse (misalign_err[g])
        );

        a_r6_issue_blocked: assert property (@(posedge clk) disable iff (rst)
            pipe_hold |-> !bwr_valid[g] && !rwr_valid[g]);
    end

    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !(|rwr_valid) && !(|mem_req) && !(|misalign_err));
endmodule

// File: tb/test_load_exec_unit.sv
`timescale 1ns/1ps
module test_load_exec_unit;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0]            iss_valid = '0;
    logic [NS-1:0][1:0]       iss_size = '0;
    logic [NS-1:0]            iss_unsigned = '0;
    logic [NS-1:0][31:0]      iss_base = '0;
    logic [NS-1:0][31:0]      iss_offset = '0;
    logic [NS-1:0][4:0]       iss_breg = '0;
    logic [NS-1:0][4:0]       iss_dst = '0;
    logic                     pipe_hold;
    logic [NS-1:0]            bwr_valid;
    logic [NS-1:0][4:0]       bwr_idx;
    logic [NS-1:0][31:0]      bwr_data;
    logic [NS-1:0]            mem_req;
    logic [NS-1:0][31:0]      mem_addr;
    logic [NS-1:0][31:0]      mem_rdata;
    logic [NS-1:0]            mem_ready;
    logic [NS-1:0]            rwr_valid;
    logic [NS-1:0][4:0]       rwr_idx;
    logic [NS-1:0][31:0]      rwr_data;
    logic [NS-1:0]            misalign_err;

    load_exec_unit #(.NSLOT(NS)) i_load_exec_unit (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_size(iss_size),
        .iss_unsigned(iss_unsigned), .iss_base(iss_base), .iss_offset(iss_offset),
        .iss_breg(iss_breg), .iss_dst(iss_dst), .pipe_hold(pipe_hold),
        .bwr_valid(bwr_valid), .bwr_idx(bwr_idx), .bwr_data(bwr_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .rwr_valid(rwr_valid), .rwr_idx(rwr_idx),
        .rwr_data(rwr_data), .misalign_err(misalign_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int miss_left [NS];

    // logs filled at the falling edge
    int          r_n [NS];
    int          r_cyc [NS][16];
    logic [4:0]  r_idx [NS][16];
    logic [31:0] r_dat [NS][16];
    int          b_n [NS];
    int          b_cyc [NS][16];
    logic [4:0]  b_idx [NS][16];
    logic [31:0] b_dat [NS][16];
    int          e_n [NS];
    int          e_cyc [NS][16];
    int          m_n [NS];
    int          m_cyc [NS];
    logic [31:0] m_adr [NS];
    int          hold_n;

    function automatic logic [31:0] mword(logic [5:0] i);
        return {8'h80 | {2'b00, i}, 8'h11 + {2'b00, i}, 8'h30 ^ {2'b00, i}, {2'b00, i}};
    endfunction

    function automatic logic [31:0] expect_load(logic [1:0] sz, logic u, logic [31:0] a);
        logic [31:0] w;
        logic [7:0]  b;
        logic [15:0] h;
        w = mword(a[7:2]);
        b = 8'(w >> (8 * a[1:0]));
        h = a[1] ? w[31:16] : w[15:0];
        if (sz == 2'b00) return u ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 2'b01) return u ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            mem_rdata[s] = mword(mem_addr[s][7:2]);
            mem_ready[s] = (miss_left[s] == 0);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int s = 0; s < NS; s++)
            if (mem_req[s] && miss_left[s] != 0) miss_left[s] <= miss_left[s] - 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (pipe_hold) hold_n++;
            for (int s = 0; s < NS; s++) begin
                if (rwr_valid[s] && r_n[s] < 16) begin
                    r_cyc[s][r_n[s]] = cyc; r_idx[s][r_n[s]] = rwr_idx[s];
                    r_dat[s][r_n[s]] = rwr_data[s]; r_n[s]++;
                end
                if (bwr_valid[s] && b_n[s] < 16) begin
                    b_cyc[s][b_n[s]] = cyc; b_idx[s][b_n[s]] = bwr_idx[s];
                    b_dat[s][b_n[s]] = bwr_data[s]; b_n[s]++;
                end
                if (misalign_err[s] && e_n[s] < 16) begin
                    e_cyc[s][e_n[s]] = cyc; e_n[s]++;
                end
                if (mem_req[s]) begin
                    if (m_n[s] == 0) begin m_cyc[s] = cyc; m_adr[s] = mem_addr[s]; end
                    m_n[s]++;
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        hold_n = 0;
        for (int s = 0; s < NS; s++) begin
            r_n[s] = 0; b_n[s] = 0; e_n[s] = 0; m_n[s] = 0; miss_left[s] = 0;
        end
    endtask

    task automatic put(int s, logic [1:0] sz, logic u, logic [31:0] b, logic [31:0] o,
                       logic [4:0] br, logic [4:0] d);
        iss_valid[s] = 1'b1; iss_size[s] = sz; iss_unsigned[s] = u;
        iss_base[s] = b; iss_offset[s] = o; iss_breg[s] = br; iss_dst[s] = d;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        iss_valid = '0;
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10", "rwr_valid", 32'(rwr_valid), 0);
        chk("R10", "bwr_valid", 32'(bwr_valid), 0);
        chk("R10", "mem_req", 32'(mem_req), 0);
        chk("R10", "misalign_err", 32'(misalign_err), 0);
        chk("R10", "pipe_hold", 32'(pipe_hold), 0);
    endtask

    task automatic t_word();
        int c0;
        clear_logs();
        put(0, 2'b10, 1'b0, 32'h40, 32'h8, 5'd3, 5'd9);
        c0 = cyc; tick();
        put(0, 2'b11, 1'b0, 32'h44, 32'h4, 5'd4, 5'd10);
        tick(); idle(8);
        chk("R1", "word result count", r_n[0], 2);
        chk("R1", "word result cycle", r_cyc[0][0], c0 + 4);
        chk("R1", "word result index", 32'(r_idx[0][0]), 9);
        chk("R3", "word data", r_dat[0][0], mword(6'd16));
        chk("R3", "size 11 data", r_dat[0][1], mword(6'd17));
        chk("R2", "base write cycle", b_cyc[0][0], c0);
        chk("R2", "base write index", 32'(b_idx[0][0]), 3);
        chk("R2", "base write data", b_dat[0][0], 32'h48);
        chk("R2", "request cycle", m_cyc[0], c0 + 2);
        chk("R2", "request address", m_adr[0], 32'h40);
    endtask

    task automatic t_half();
        int c0;
        logic [31:0] a [4] = '{32'h50, 32'h52, 32'h52, 32'h50};
        logic        u [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
        clear_logs();
        c0 = cyc;
        for (int i = 0; i < 4; i++) begin
            put(0, 2'b01, u[i], a[i], 32'h2, 5'd1, 5'(16 + i));
            tick();
        end
        idle(8);
        chk("R4", "half result count", r_n[0], 4);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "half data", r_dat[0][i], expect_load(2'b01, u[i], a[i]));
            chk("R7", "half back-to-back cycle", r_cyc[0][i], c0 + 4 + i);
        end
    endtask

    task automatic t_byte();
        int c0;
        clear_logs();
        c0 = cyc;
        for (int i = 0; i < 8; i++) begin
            put(1, 2'b00, 1'(i / 4), 32'h60 + 32'(i % 4), 32'h1, 5'd2, 5'(i));
            tick();
        end
        idle(8);
        chk("R5", "byte result count", r_n[1], 8);
        for (int i = 0; i < 8; i++) begin
            chk("R5", "byte data", r_dat[1][i],
                expect_load(2'b00, 1'(i / 4), 32'h60 + 32'(i % 4)));
            chk("R7", "byte back-to-back cycle", r_cyc[1][i], c0 + 4 + i);
        end
    endtask

    task automatic t_same_dst();
        int c0;
        clear_logs();
        put(0, 2'b10, 1'b0, 32'h70, 32'h4, 5'd6, 5'd5);
        c0 = cyc; tick();
        put(0, 2'b10, 1'b0, 32'h74, 32'h4, 5'd6, 5'd5);
        tick(); idle(8);
        chk("R7", "same dst count", r_n[0], 2);
        chk("R7", "same dst first cycle", r_cyc[0][0], c0 + 4);
        chk("R7", "same dst second cycle", r_cyc[0][1], c0 + 5);
        chk("R7", "same dst first data", r_dat[0][0], mword(6'd28));
        chk("R7", "same dst second data", r_dat[0][1], mword(6'd29));
    endtask

    task automatic t_dual();
        int c0;
        clear_logs();
        put(0, 2'b10, 1'b0, 32'h80, 32'h4, 5'd20, 5'd21);
        put(1, 2'b01, 1'b1, 32'h8e, 32'h2, 5'd22, 5'd23);
        c0 = cyc; tick(); idle(8);
        chk("R8", "slot0 count", r_n[0], 1);
        chk("R8", "slot1 count", r_n[1], 1);
        chk("R8", "slot0 cycle", r_cyc[0][0], c0 + 4);
        chk("R8", "slot1 cycle", r_cyc[1][0], c0 + 4);
        chk("R8", "slot0 data", r_dat[0][0], mword(6'd32));
        chk("R8", "slot1 data", r_dat[1][0], expect_load(2'b01, 1'b1, 32'h8e));
        chk("R8", "slot1 index", 32'(r_idx[1][0]), 23);
        chk("R8", "slot1 base data", b_dat[1][0], 32'h90);
    endtask

    task automatic t_stall();
        int c0;
        clear_logs();
        miss_left[0] = 3;
        put(0, 2'b10, 1'b0, 32'h90, 32'h4, 5'd1, 5'd11);
        put(1, 2'b10, 1'b0, 32'h94, 32'h4, 5'd2, 5'd13);
        c0 = cyc; tick();
        put(0, 2'b10, 1'b0, 32'h98, 32'h4, 5'd1, 5'd12);
        tick();
        tick();
        put(1, 2'b10, 1'b0, 32'h9c, 32'h4, 5'd31, 5'd30);
        tick(); idle(10);
        chk("R6", "hold cycles", hold_n, 3);
        chk("R6", "slot0 count", r_n[0], 2);
        chk("R6", "slot0 first cycle", r_cyc[0][0], c0 + 7);
        chk("R6", "slot0 second cycle", r_cyc[0][1], c0 + 8);
        chk("R6", "slot0 first data", r_dat[0][0], mword(6'd36));
        chk("R6", "slot0 second data", r_dat[0][1], mword(6'd38));
        chk("R6", "slot1 frozen cycle", r_cyc[1][0], c0 + 7);
        chk("R6", "slot1 result count (issue in hold ignored)", r_n[1], 1);
        chk("R6", "slot1 base writes (issue in hold ignored)", b_n[1], 1);
    endtask

    task automatic t_misalign();
        int c0;
        clear_logs();
        put(0, 2'b10, 1'b0, 32'h41, 32'h4, 5'd7, 5'd8);
        put(1, 2'b01, 1'b0, 32'h53, 32'h2, 5'd9, 5'd10);
        c0 = cyc; tick(); idle(8);
        chk("R9", "slot0 err count", e_n[0], 1);
        chk("R9", "slot1 err count", e_n[1], 1);
        chk("R9", "slot0 err cycle", e_cyc[0][0], c0 + 4);
        chk("R9", "no result", r_n[0] + r_n[1], 0);
        chk("R9", "no request", m_n[0] + m_n[1], 0);
        chk("R9", "base still written", b_dat[0][0], 32'h45);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL R10 watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    initial begin
        clear_logs();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        tick();
        t_word();
        t_half();
        t_byte();
        t_same_dst();
        t_dual();
        t_stall();
        t_misalign();
        finish_run();
    end
endmodule